// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects up to 32 interrupt inputs, conditions each one as a level or an edge, and presents a single active-low request line to a processor. Software programs one mode word and one vector word per source. It turns sources on and off through a pair of write-one command words. Set bits in an enable command turn sources on, set bits in a disable command turn them off, and the resulting mask can be read back.

When the processor takes the request, it reads the claim word. The read returns the vector of the best eligible source and records that source's priority on an eight-entry nesting stack. From then on, only strictly higher priorities can raise the request line. A write of any value to the end-of-interrupt word drops one stack level. When a claim finds nothing eligible, it returns a programmable spurious vector and the stack is left as it is.

Registers sit on a plain single-cycle word bus, and read data is registered. Word addresses: 0..31 are the mode words, 32..63 are the vector words, and 64..72 are the control words (claim 64, enable-set 65, enable-clear 66, mask 67, pending-clear 68, end-of-interrupt 69, spurious vector 70, debug stub 71, pending 72).

Top module: `prio_vic`

## Requirements
- R1: After reset, irq_n is 1, the enable mask reads 0, and every mode word reads 0: priority 0, high-level trigger.
- R2: A write to enable-set (65) turns on each source whose data bit is 1, and a write to enable-clear (66) turns off each such source. Zero bits change nothing. The mask (67) reads back the current enables.
- R3: Mode word bits [2:0] hold the priority, where 7 is the most urgent. Bits [5:4] hold the trigger: 0 high level, 1 rising edge, 2 low level, 3 falling edge. Both fields read back.
- R4: For sources 1 to 24, a mode write that asks for trigger 2 or 3 leaves the trigger unchanged and still updates the priority. Source 0 and sources 25 to 31 accept all four triggers.
- R5: Every input passes through two synchronizing flops. A level source is pending only while its synchronized input is at the active level. An edge source latches pending on the selected edge. The pending word (72) reads all sources.
- R6: A claim read (64) returns the vector word of the enabled pending source with the highest priority. Among equal priorities, the lowest source number wins.
- R7: A claim read when no source is eligible returns the spurious-vector word (70), and the stack is left unchanged.
- R8: A successful claim pushes the winner's priority onto the stack. While the stack is not empty, only sources with a strictly higher priority than the top entry are eligible. Any write to 69 pops one level. A pop on an empty stack does nothing.
- R9: Writing ones to pending-clear (68) clears the latched pending of those edge sources. A successful claim also clears the latched pending of the claimed edge source.
- R10: irq_n is a register. After each clock it is 0 exactly when some source was eligible in the cycle before that clock.
- R11: The debug word (71) is a single read/write bit that resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | 32 | Raw interrupt inputs, one bit per source |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The in-design properties are checked on every cycle, and they cover these relations:
- the winning index always names a pending, enabled source;
- the stack never pushes when full, and it only pushes rising priorities;
- a pop on an empty stack does nothing;
- the enable commands take effect;
- a spurious claim returns the spurious word;
- internal sources never hold a forbidden trigger;
- a cleared edge stays clear unless a new edge arrives.

Only the bench's scenarios can show the other behaviours: the exact synchronizer latency, the lowest-number tie break, preemption by a higher priority during nesting, a return to idle after a burst of end-of-interrupt writes, and claims that clear edge pending. For these, a behavioural model is compared with both outputs on every clock.

// File: rtl/prio_vic_pkg.sv
package prio_vic_pkg;

  typedef enum logic [1:0] {
    TRIG_HIGH = 2'd0,
    TRIG_RISE = 2'd1,
    TRIG_LOW  = 2'd2,
    TRIG_FALL = 2'd3
  } trig_e;

  // control word offsets above the two per-source banks
  localparam int OFF_CLAIM = 0;
  localparam int OFF_ENSET = 1;
  localparam int OFF_ENCLR = 2;
  localparam int OFF_MASK  = 3;
  localparam int OFF_PCLR  = 4;
  localparam int OFF_EOI   = 5;
  localparam int OFF_SPUR  = 6;
  localparam int OFF_DBG   = 7;
  localparam int OFF_PEND  = 8;

  function automatic logic trig_is_edge(trig_e t);
    return (t == TRIG_RISE) || (t == TRIG_FALL);
  endfunction

  // sources strictly between source 0 and the first external one are on-chip
  function automatic logic trig_ok(int unsigned src, int unsigned ext_base, trig_e t);
    if (src > 0 && src < ext_base) return (t == TRIG_HIGH) || (t == TRIG_RISE);
    return 1'b1;
  endfunction

endpackage

// File: rtl/prio_vic_src.sv
module prio_vic_src
  import prio_vic_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pin,
  input  trig_e trig,
  input  logic  clr,
  output logic  pending
);
  logic s1_q, s2_q, prv_q, edge_q;
  logic edge_hit;

  assign edge_hit = (trig == TRIG_RISE &&  s2_q && !prv_q) ||
                    (trig == TRIG_FALL && !s2_q &&  prv_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prv_q  <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      s1_q   <= pin;
      s2_q   <= s1_q;
      prv_q  <= s2_q;
      edge_q <= trig_is_edge(trig) ? ((edge_q & ~clr) | edge_hit) : 1'b0;
    end
  end

  always_comb begin
    if (trig_is_edge(trig))      pending = edge_q;
    else if (trig == TRIG_HIGH)  pending = s2_q;
    else                         pending = !s2_q;
  end

  // R9: a clear with no fresh edge leaves the latch empty
  p_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !edge_hit) |=> !edge_q);

endmodule

// File: rtl/prio_vic_arb.sv
module prio_vic_arb #(
  parameter int NSRC = 32,
  parameter int PW   = 3,
  localparam int IW  = $clog2(NSRC)
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] cand,
  input  logic [PW-1:0]   prio [NSRC],
  output logic            win_valid,
  output logic [IW-1:0]   win_idx,
  output logic [PW-1:0]   win_prio
);
  // scan downwards with >= so that the lowest index keeps a tie
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_prio  = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (cand[i] && (!win_valid || prio[i] >= win_prio)) begin
        win_valid = 1'b1;
        win_idx   = IW'(i);
        win_prio  = prio[i];
      end
    end
  end

  p_win_cand_r6: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> cand[win_idx]);

endmodule

// File: rtl/prio_vic_stack.sv
module prio_vic_stack #(
  parameter int DEPTH = 8,
  parameter int PW    = 3
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [PW-1:0] push_prio,
  input  logic          pop,
  output logic [PW-1:0] top_prio,
  output logic          empty
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int SW = $clog2(DEPTH);

  logic [PW-1:0] lvl_q [DEPTH];
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] top_i;
  logic          full;

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));
  assign top_i = cnt_q - CW'(1);
  assign top_prio = empty ? '0 : lvl_q[top_i[SW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) lvl_q[i] <= '0;
    end else if (push && !full) begin
      lvl_q[cnt_q[SW-1:0]] <= push_prio;
      cnt_q <= cnt_q + CW'(1);
    end else if (pop && !empty) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  p_push_room_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  p_nest_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !empty) |-> (push_prio > top_prio));
  p_pop_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && empty) |=> empty);

endmodule

// File: rtl/prio_vic.sv
module prio_vic
  import prio_vic_pkg::*;
#(
  parameter int NSRC     = 32,
  parameter int PW       = 3,
  parameter int DW       = 32,
  parameter int AW       = 8,
  parameter int EXT_BASE = 25
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_src,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            irq_n
);
  localparam int DEPTH    = 1 << PW;
  localparam int IW       = $clog2(NSRC);
  localparam int VEC_BASE = NSRC;
  localparam int CTL_BASE = 2 * NSRC;
  localparam logic [AW-1:0] A_CLAIM = AW'(CTL_BASE + OFF_CLAIM);
  localparam logic [AW-1:0] A_ENSET = AW'(CTL_BASE + OFF_ENSET);
  localparam logic [AW-1:0] A_ENCLR = AW'(CTL_BASE + OFF_ENCLR);
  localparam logic [AW-1:0] A_MASK  = AW'(CTL_BASE + OFF_MASK);
  localparam logic [AW-1:0] A_PCLR  = AW'(CTL_BASE + OFF_PCLR);
  localparam logic [AW-1:0] A_EOI   = AW'(CTL_BASE + OFF_EOI);
  localparam logic [AW-1:0] A_SPUR  = AW'(CTL_BASE + OFF_SPUR);
  localparam logic [AW-1:0] A_DBG   = AW'(CTL_BASE + OFF_DBG);
  localparam logic [AW-1:0] A_PEND  = AW'(CTL_BASE + OFF_PEND);

  logic [PW-1:0]   prio_q [NSRC];
  trig_e           trig_q [NSRC];
  logic [DW-1:0]   vec_q  [NSRC];
  logic [NSRC-1:0] en_q, pend, cand, clr_bits, claim_hot;
  logic [DW-1:0]   spur_q, rdata_q, rd_word;
  logic            dbg_q, irq_q;

  // named internal events
  logic            win_valid, stk_empty, eligible, claim_rd, push, pop;
  logic [IW-1:0]   win_idx;
  logic [PW-1:0]   win_prio, stk_top;
  logic [IW-1:0]   a_idx;

  assign a_idx     = bus_addr[IW-1:0];
  assign cand      = pend & en_q;
  assign eligible  = win_valid && (stk_empty || win_prio > stk_top);
  assign claim_rd  = bus_rd && bus_addr == A_CLAIM;
  assign push      = claim_rd && eligible;
  assign pop       = bus_wr && bus_addr == A_EOI;
  assign claim_hot = push ? (NSRC'(1) << win_idx) : '0;
  assign clr_bits  = ((bus_wr && bus_addr == A_PCLR) ? bus_wdata[NSRC-1:0] : '0) | claim_hot;

  // per-source mode and vector words
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) begin
        prio_q[i] <= '0;
        trig_q[i] <= TRIG_HIGH;
        vec_q[i]  <= '0;
      end
    end else if (bus_wr) begin
      for (int i = 0; i < NSRC; i++) begin
        if (bus_addr == AW'(i)) begin
          prio_q[i] <= bus_wdata[PW-1:0];
          if (trig_ok(i, EXT_BASE, trig_e'(bus_wdata[5:4])))
            trig_q[i] <= trig_e'(bus_wdata[5:4]);
        end
        if (bus_addr == AW'(VEC_BASE + i)) vec_q[i] <= bus_wdata;
      end
    end
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    prio_vic_src u_src (
      .clk(clk), .rst_n(rst_n), .pin(irq_src[g]), .trig(trig_q[g]),
      .clr(clr_bits[g]), .pending(pend[g])
    );
    if (g > 0 && g < EXT_BASE) begin : g_onchip
      p_int_trig_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(trig_q[g] inside {TRIG_LOW, TRIG_FALL}));
    end
  end

  prio_vic_arb #(.NSRC(NSRC), .PW(PW)) u_arb (
    .clk(clk), .rst_n(rst_n), .cand(cand), .prio(prio_q),
    .win_valid(win_valid), .win_idx(win_idx), .win_prio(win_prio)
  );

  prio_vic_stack #(.DEPTH(DEPTH), .PW(PW)) u_stk (
    .clk(clk), .rst_n(rst_n), .push(push), .push_prio(win_prio), .pop(pop),
    .top_prio(stk_top), .empty(stk_empty)
  );

  // read mux
  always_comb begin
    rd_word = '0;
    if (bus_addr < AW'(VEC_BASE)) begin
      rd_word[PW-1:0] = prio_q[a_idx];
      rd_word[5:4]    = trig_q[a_idx];
    end else if (bus_addr < AW'(CTL_BASE)) begin
      rd_word = vec_q[a_idx];
    end else begin
      case (bus_addr)
        A_CLAIM: rd_word = eligible ? vec_q[win_idx] : spur_q;
        A_MASK:  rd_word = DW'(en_q);
        A_SPUR:  rd_word = spur_q;
        A_DBG:   rd_word = DW'(dbg_q);
        A_PEND:  rd_word = DW'(pend);
        default: rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      spur_q  <= '0;
      dbg_q   <= 1'b0;
      rdata_q <= '0;
      irq_q   <= 1'b1;
    end else begin
      irq_q <= !eligible;
      if (bus_rd) rdata_q <= rd_word;
      if (bus_wr) begin
        if (bus_addr == A_ENSET) en_q   <= en_q | bus_wdata[NSRC-1:0];
        if (bus_addr == A_ENCLR) en_q   <= en_q & ~bus_wdata[NSRC-1:0];
        if (bus_addr == A_SPUR)  spur_q <= bus_wdata;
        if (bus_addr == A_DBG)   dbg_q  <= bus_wdata[0];
      end
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_n     = irq_q;

  p_en_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_ENSET) |=>
      ((en_q & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0])));
  p_en_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_ENCLR) |=> ((en_q & $past(bus_wdata[NSRC-1:0])) == '0));
  p_spur_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_rd && !eligible) |=> (bus_rdata == $past(spur_q)));
  p_irq_cand_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> $past(|cand));

endmodule

// File: tb/prio_vic_tb.sv
`timescale 1ns/1ps
module prio_vic_tb;
  localparam int CLAIM = 64, ENSET = 65, ENCLR = 66, MASK = 67, PCLR = 68;
  localparam int EOI = 69, SPUR = 70, DBG = 71, PEND = 72;

  logic        clk = 0, rst_n = 0;
  logic [31:0] pins = '0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_n;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  prio_vic u_dut (
    .clk(clk), .rst_n(rst_n), .irq_src(pins), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          m_prio [32];
  int          m_trig [32];
  logic [31:0] m_vec  [32];
  logic [31:0] m_s1, m_s2, m_prv, m_edge, m_en, m_spur, m_rdata;
  bit          m_dbg, m_irqn;
  int          m_stk [$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) begin m_prio[i] = 0; m_trig[i] = 0; m_vec[i] = 0; end
      m_s1 = 0; m_s2 = 0; m_prv = 0; m_edge = 0; m_en = 0; m_spur = 0; m_rdata = 0;
      m_dbg = 0; m_irqn = 1; m_stk.delete();
    end else begin
      logic [31:0] pend, clr;
      int best, bp, t;
      bit elig, hit, isedge;
      for (int i = 0; i < 32; i++) begin
        isedge = (m_trig[i] == 1 || m_trig[i] == 3);
        pend[i] = isedge ? m_edge[i] : (m_trig[i] == 0 ? m_s2[i] : !m_s2[i]);
      end
      best = -1; bp = 0;
      for (int i = 0; i < 32; i++)
        if (pend[i] && m_en[i] && (best < 0 || m_prio[i] > bp)) begin best = i; bp = m_prio[i]; end
      elig = (best >= 0) && (m_stk.size() == 0 || bp > m_stk[$]);
      if (bus_rd) begin
        if (bus_addr < 32) m_rdata = (m_trig[bus_addr] << 4) | m_prio[bus_addr];
        else if (bus_addr < 64) m_rdata = m_vec[bus_addr - 32];
        else if (bus_addr == CLAIM) m_rdata = elig ? m_vec[best] : m_spur;
        else if (bus_addr == MASK) m_rdata = m_en;
        else if (bus_addr == SPUR) m_rdata = m_spur;
        else if (bus_addr == DBG) m_rdata = {31'b0, m_dbg};
        else if (bus_addr == PEND) m_rdata = pend;
        else m_rdata = 0;
      end
      clr = (bus_wr && bus_addr == PCLR) ? bus_wdata : 32'h0;
      if (bus_rd && bus_addr == CLAIM && elig) begin m_stk.push_back(bp); clr[best] = 1'b1; end
      if (bus_wr && bus_addr == EOI && m_stk.size() > 0) void'(m_stk.pop_back());
      for (int i = 0; i < 32; i++) begin
        isedge = (m_trig[i] == 1 || m_trig[i] == 3);
        hit = (m_trig[i] == 1 && m_s2[i] && !m_prv[i]) || (m_trig[i] == 3 && !m_s2[i] && m_prv[i]);
        m_edge[i] = isedge ? ((m_edge[i] && !clr[i]) || hit) : 1'b0;
      end
      m_prv = m_s2; m_s2 = m_s1; m_s1 = pins;
      m_irqn = !elig;
      if (bus_wr) begin
        if (bus_addr < 32) begin
          t = bus_wdata[5:4];
          m_prio[bus_addr] = bus_wdata[2:0];
          if (!(bus_addr > 0 && bus_addr < 25 && t >= 2)) m_trig[bus_addr] = t;
        end else if (bus_addr < 64) m_vec[bus_addr - 32] = bus_wdata;
        else if (bus_addr == ENSET) m_en = m_en | bus_wdata;
        else if (bus_addr == ENCLR) m_en = m_en & ~bus_wdata;
        else if (bus_addr == SPUR) m_spur = bus_wdata;
        else if (bus_addr == DBG) m_dbg = bus_wdata[0];
      end
    end
  end

  // compare both outputs with the model on every cycle, away from the active edge
  always @(negedge clk) begin
    chk("R10 irq_n vs model", {31'b0, irq_n}, {31'b0, m_irqn});
    chk("R6 rdata vs model", bus_rdata, m_rdata);
  end

  // ---------------- stimulus ----------------
  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask
  task automatic wr(input int a, input logic [31:0] d);
    @(posedge clk); #1 bus_wr = 1; bus_addr = 8'(a); bus_wdata = d;
    @(posedge clk); #1 bus_wr = 0;
  endtask
  task automatic rd(input int a, output logic [31:0] d);
    @(posedge clk); #1 bus_rd = 1; bus_addr = 8'(a);
    @(posedge clk); #1 bus_rd = 0; d = bus_rdata;
  endtask
  task automatic setpin(input int n, input logic v);
    @(posedge clk); #1 pins[n] = v;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk("R1 irq_n after reset", {31'b0, irq_n}, 32'h1);
    rd(MASK, d); chk("R1 mask after reset", d, 32'h0);
    rd(5, d);    chk("R1 mode after reset", d, 32'h0);
    rd(DBG, d);  chk("R11 debug resets to 0", d, 32'h0);
    wr(DBG, 32'hFFFF_FFFF); rd(DBG, d); chk("R11 debug read/write", d, 32'h1);
    wr(DBG, 0);

    wr(ENSET, 32'hF0); wr(ENSET, 32'h1);
    rd(MASK, d); chk("R2 enable set", d, 32'hF1);
    wr(ENCLR, 32'h30); rd(MASK, d); chk("R2 enable clear", d, 32'hC1);
    wr(ENCLR, 32'h0);  rd(MASK, d); chk("R2 zero clear has no effect", d, 32'hC1);
    wr(ENSET, 32'h0);  rd(MASK, d); chk("R2 zero set has no effect", d, 32'hC1);
    wr(ENCLR, 32'hFFFF_FFFF);

    wr(30, 32'h35); rd(30, d); chk("R3 mode readback", d, 32'h35);
    wr(3, 32'h26);  rd(3, d);  chk("R4 low level refused on-chip", d, 32'h06);
    wr(3, 32'h37);  rd(3, d);  chk("R4 falling refused on-chip", d, 32'h07);
    wr(3, 32'h17);  rd(3, d);  chk("R4 rising accepted on-chip", d, 32'h17);
    wr(0, 32'h22);  rd(0, d);  chk("R4 source 0 takes low level", d, 32'h22);
    wr(0, 0); wr(3, 0); wr(30, 0);

    for (int i = 0; i < 32; i++) wr(32 + i, 32'h100 + i);
    wr(SPUR, 32'hDEAD);
    rd(CLAIM, d); chk("R7 spurious when idle", d, 32'hDEAD);

    // level sources, priorities and nesting
    wr(4, 2); wr(7, 2); wr(9, 5);
    wr(ENSET, (32'h1 << 4) | (32'h1 << 7) | (32'h1 << 9));
    setpin(4, 1);
    idle(2); chk("R10 not yet through synchronizer", {31'b0, irq_n}, 32'h1);
    idle(1); chk("R5 level raises request", {31'b0, irq_n}, 32'h0);
    rd(PEND, d); chk("R5 pending word", d, 32'h10);
    setpin(7, 1); idle(3);
    rd(CLAIM, d); chk("R6 tie goes to lowest source", d, 32'h104);
    idle(1); chk("R8 equal priority masked", {31'b0, irq_n}, 32'h1);
    setpin(9, 1); idle(3);
    chk("R8 higher priority preempts", {31'b0, irq_n}, 32'h0);
    rd(CLAIM, d); chk("R6 higher priority wins", d, 32'h109);
    rd(CLAIM, d); chk("R7 nothing above top", d, 32'hDEAD);
    setpin(9, 0); idle(3);
    wr(EOI, 32'h1234); idle(1);
    chk("R8 one pop keeps outer level", {31'b0, irq_n}, 32'h1);
    wr(EOI, 0); idle(1);
    chk("R8 empty stack reopens", {31'b0, irq_n}, 32'h0);
    rd(CLAIM, d); chk("R6 reclaim after pops", d, 32'h104);
    wr(EOI, 0);
    setpin(4, 0); setpin(7, 0); idle(3);
    chk("R5 level drops request", {31'b0, irq_n}, 32'h1);
    wr(EOI, 0); wr(EOI, 0); wr(EOI, 0);
    chk("R8 pop on empty ignored", {31'b0, irq_n}, 32'h1);

    // rising edge, clear by command and by claim
    wr(26, 32'h11); wr(ENSET, 32'h1 << 26);
    setpin(26, 1); setpin(26, 0); idle(4);
    rd(PEND, d); chk("R5 rising edge latched", d, 32'h1 << 26);
    wr(PCLR, 32'h1 << 26); rd(PEND, d); chk("R9 clear command", d, 32'h0);
    idle(1); chk("R9 request gone after clear", {31'b0, irq_n}, 32'h1);
    setpin(26, 1); setpin(26, 0); idle(4);
    rd(CLAIM, d); chk("R9 edge claim vector", d, 32'h11A);
    rd(PEND, d); chk("R9 claim clears edge", d, 32'h0);
    wr(EOI, 0);

    // falling edge on an external source
    setpin(30, 1); idle(3);
    wr(30, 32'h33); wr(ENSET, 32'h1 << 30);
    setpin(30, 0); idle(4);
    rd(PEND, d); chk("R5 falling edge latched", d, 32'h1 << 30);
    rd(CLAIM, d); chk("R6 falling edge claim", d, 32'h11E);
    wr(EOI, 0);

    // three nested claims, then eight pops return to idle
    wr(20, 1); wr(21, 3); wr(22, 6);
    wr(ENSET, 32'h7 << 20);
    setpin(20, 1); idle(3); rd(CLAIM, d); chk("R8 nest level 1", d, 32'h114);
    setpin(21, 1); idle(3); rd(CLAIM, d); chk("R8 nest level 2", d, 32'h115);
    setpin(22, 1); idle(3); rd(CLAIM, d); chk("R8 nest level 3", d, 32'h116);
    rd(CLAIM, d); chk("R7 spurious at top level", d, 32'hDEAD);
    for (int i = 0; i < 8; i++) wr(EOI, 32'(i));
    idle(1); chk("R8 eight pops reach idle", {31'b0, irq_n}, 32'h0);
    rd(CLAIM, d); chk("R6 best after idle", d, 32'h116);
    wr(EOI, 0);
    setpin(20, 0); setpin(21, 0); setpin(22, 0); idle(5);

    done = 1;
    summary();
    $finish;
  end
endmodule